// File: doc/BRIEF.md
# Serial RGB Byte Serializer

This block drives an 8-bit serial RGB panel. Each 24-bit pixel goes out as three consecutive bytes, one byte per clock, so the byte clock runs at three times the pixel rate of an equivalent parallel panel. The required clock is horizontal total × 3 × vertical total × frame rate. The block also produces horizontal sync, vertical sync and data enable. All horizontal counts are in pixels, not in byte slots.

The timing is set by static configuration inputs: sync width, back porch, visible size and front porch, for each axis. The horizontal total is the sum of the four horizontal values, and the vertical total is the sum of the four vertical values. For example, a 240x320 panel with 10/10/46 horizontal and 4/4/8 vertical blanking gives totals of 306 by 336.

Pixels enter through a valid/ready handshake that accepts at most one pixel every third clock, into a single holding register. A colour-order input permutes the three bytes so that swapped channels on the panel side can be corrected. A pixel that is missing when it is due is sent as zeros and latches an underrun flag.

Top module: `srgb_serializer`

## Requirements
- R1: During reset and in the first cycle after it, the block is at slot 0 of pixel position 0 of line 0. In that state hsync_o and vsync_o are high (for nonzero sync widths), and de_o, pix_ready_o, data_o and underrun_o are all 0.
- R2: A slot counter steps 0,1,2 once per clock. Every pixel position lasts exactly three clocks. A line is HPW+HBP+HACT+HFP positions long, and a frame is VPW+VBP+VACT+VFP lines long, both wrapping to 0.
- R3: hsync_o is high for pixel positions 0 to HPW-1 of each line. vsync_o is high for lines 0 to VPW-1. Both change only at slot 0.
- R4: de_o is high on all three slots of a position whose pixel index lies in [HPW+HBP, HPW+HBP+HACT) and whose line lies in [VPW+VBP, VPW+VBP+VACT). It is low everywhere else.
- R5: pix_ready_o is high only in slot 2 of a position whose following position is active. This includes the last blanking position before the first active pixel of a line.
- R6: A pixel accepted on pix_valid_i and pix_ready_o is sent during the next position. The pixel holds R in bits 23:16, G in bits 15:8 and B in bits 7:0. The order_i code sets the bytes sent in slots 0,1,2: 0=R,G,B; 1=R,B,G; 2=G,R,B; 3=G,B,R; 4=B,R,G; 5=B,G,R; codes 6 and 7 act as 0.
- R7: data_o is 0 whenever de_o is low.
- R8: If pix_valid_i is low while pix_ready_o is high, the following active pixel sends 0 on all three slots. underrun_o goes high one clock after that pixel's first slot and stays high until reset.
- R9: After an underrun, later pixels delivered on time are sent normally.
- R10: Zero back porch, zero front porch and zero vertical back porch are handled, with the same sync, enable and ready rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_hpw_i | input | HW | Horizontal sync width, pixels |
| cfg_hbp_i | input | HW | Horizontal back porch, pixels |
| cfg_hact_i | input | HW | Visible pixels per line |
| cfg_hfp_i | input | HW | Horizontal front porch, pixels |
| cfg_vpw_i | input | VW | Vertical sync width, lines |
| cfg_vbp_i | input | VW | Vertical back porch, lines |
| cfg_vact_i | input | VW | Visible lines |
| cfg_vfp_i | input | VW | Vertical front porch, lines |
| order_i | input | 3 | Colour byte order code |
| pix_i | input | 3*CW | Pixel, R high, B low |
| pix_valid_i | input | 1 | Pixel offered |
| pix_ready_o | output | 1 | Pixel taken this clock if valid |
| data_o | output | CW | Serial colour byte |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Data enable, active high |
| underrun_o | output | 1 | Sticky missing-pixel flag |

## Verification
The assertions assume that the timing configuration is held constant while out of reset, and that the line and frame totals are nonzero and fit in the counter widths. The stimulus changes configuration only while reset is held, and uses totals far below the counter range. It does change order_i between frames, because the byte order is not covered by any temporal property.

// File: rtl/srgb_ser_pkg.sv
package srgb_ser_pkg;
  localparam int unsigned NSLOT = 3;

  // channel index carried by a byte slot: 0=R 1=G 2=B
  function automatic logic [1:0] slot_chan(input logic [2:0] order, input logic [1:0] slot);
    logic [5:0] map;
    case (order)
      3'd1:    map = {2'd1, 2'd2, 2'd0};
      3'd2:    map = {2'd2, 2'd0, 2'd1};
      3'd3:    map = {2'd0, 2'd2, 2'd1};
      3'd4:    map = {2'd1, 2'd0, 2'd2};
      3'd5:    map = {2'd0, 2'd1, 2'd2};
      default: map = {2'd2, 2'd1, 2'd0};
    endcase
    return map[slot*2 +: 2];
  endfunction
endpackage

// File: rtl/srgb_timing.sv
module srgb_timing #(
  parameter int unsigned HW = 10,
  parameter int unsigned VW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [HW-1:0] hpw_i,
  input  logic [HW-1:0] hbp_i,
  input  logic [HW-1:0] hact_i,
  input  logic [HW-1:0] hfp_i,
  input  logic [VW-1:0] vpw_i,
  input  logic [VW-1:0] vbp_i,
  input  logic [VW-1:0] vact_i,
  input  logic [VW-1:0] vfp_i,
  output logic [1:0]    slot_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          ready_o
);
  logic [1:0]    slot_q;
  logic [HW-1:0] h_q, h_nx, h_tot, h_beg, h_end;
  logic [VW-1:0] v_q, v_nx, v_tot, v_beg, v_end;
  logic          h_last, v_last, wrap;

  assign h_tot  = hpw_i + hbp_i + hact_i + hfp_i;
  assign h_beg  = hpw_i + hbp_i;
  assign h_end  = h_beg + hact_i;
  assign v_tot  = vpw_i + vbp_i + vact_i + vfp_i;
  assign v_beg  = vpw_i + vbp_i;
  assign v_end  = v_beg + vact_i;
  assign h_last = (h_q == h_tot - 1'b1);
  assign v_last = (v_q == v_tot - 1'b1);
  assign wrap   = (slot_q == 2'd2);

  always_comb begin
    h_nx = h_last ? '0 : h_q + 1'b1;
    v_nx = v_q;
    if (h_last) v_nx = v_last ? '0 : v_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= 2'd0;
      h_q    <= '0;
      v_q    <= '0;
    end else begin
      slot_q <= wrap ? 2'd0 : slot_q + 2'd1;
      if (wrap) begin
        h_q <= h_nx;
        v_q <= v_nx;
      end
    end
  end

  assign slot_o  = slot_q;
  assign hsync_o = (h_q < hpw_i);
  assign vsync_o = (v_q < vpw_i);
  assign de_o    = (h_q >= h_beg) && (h_q < h_end) && (v_q >= v_beg) && (v_q < v_end);
  assign ready_o = wrap && (h_nx >= h_beg) && (h_nx < h_end) && (v_nx >= v_beg) && (v_nx < v_end);

  p_slot_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni) slot_q <= 2'd2);
  p_h_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q != 2'd2) |=> $stable(h_q));
  p_hs_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(hsync_o) |-> (slot_q == 2'd0));
  p_vs_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(vsync_o) |-> (slot_q == 2'd0));
  p_de_span_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_o && slot_q != 2'd2) |=> de_o);
endmodule

// File: rtl/srgb_pix_hold.sv
module srgb_pix_hold #(
  parameter int unsigned PW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ready_i,
  input  logic          valid_i,
  input  logic [PW-1:0] pix_i,
  input  logic          de_i,
  input  logic [1:0]    slot_i,
  output logic [PW-1:0] pix_o,
  output logic          ok_o,
  output logic          underrun_o
);
  logic [PW-1:0] pix_q;
  logic          ok_q, under_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q   <= '0;
      ok_q    <= 1'b0;
      under_q <= 1'b0;
    end else begin
      if (ready_i) begin
        ok_q <= valid_i;
        if (valid_i) pix_q <= pix_i;
      end
      if (de_i && !ok_q) under_q <= 1'b1;
    end
  end

  assign pix_o      = pix_q;
  assign ok_o       = ok_q;
  assign underrun_o = under_q;

  p_ready_slot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |-> (slot_i == 2'd2));
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> $stable(pix_q));
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    under_q |=> under_q);
endmodule

// File: rtl/srgb_byte_mux.sv
module srgb_byte_mux
  import srgb_ser_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic [3*CW-1:0] pix_i,
  input  logic            ok_i,
  input  logic            de_i,
  input  logic [1:0]      slot_i,
  input  logic [2:0]      order_i,
  output logic [CW-1:0]   byte_o
);
  logic [CW-1:0] chan [NSLOT];
  logic [CW-1:0] lane [NSLOT];

  for (genvar c = 0; c < NSLOT; c++) begin : g_chan
    assign chan[c] = pix_i[(NSLOT-1-c)*CW +: CW];
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign lane[s] = chan[slot_chan(order_i, 2'(s))];
  end

  always_comb begin
    byte_o = '0;
    if (de_i && ok_i) begin
      case (slot_i)
        2'd0:    byte_o = lane[0];
        2'd1:    byte_o = lane[1];
        default: byte_o = lane[2];
      endcase
    end
  end
endmodule

// File: rtl/srgb_serializer.sv
module srgb_serializer #(
  parameter int unsigned HW = 10,
  parameter int unsigned VW = 10,
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [HW-1:0] cfg_hpw_i,
  input  logic [HW-1:0] cfg_hbp_i,
  input  logic [HW-1:0] cfg_hact_i,
  input  logic [HW-1:0] cfg_hfp_i,
  input  logic [VW-1:0] cfg_vpw_i,
  input  logic [VW-1:0] cfg_vbp_i,
  input  logic [VW-1:0] cfg_vact_i,
  input  logic [VW-1:0] cfg_vfp_i,
  input  logic [2:0]    order_i,
  input  logic [3*CW-1:0] pix_i,
  input  logic          pix_valid_i,
  output logic          pix_ready_o,
  output logic [CW-1:0] data_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          underrun_o
);
  localparam int unsigned PW = 3 * CW;

  logic [1:0]    slot;
  logic          ready, de, ok;
  logic [PW-1:0] held;

  srgb_timing #(.HW(HW), .VW(VW)) u_timing (
    .clk_i, .rst_ni,
    .hpw_i(cfg_hpw_i), .hbp_i(cfg_hbp_i), .hact_i(cfg_hact_i), .hfp_i(cfg_hfp_i),
    .vpw_i(cfg_vpw_i), .vbp_i(cfg_vbp_i), .vact_i(cfg_vact_i), .vfp_i(cfg_vfp_i),
    .slot_o(slot), .hsync_o, .vsync_o, .de_o(de), .ready_o(ready)
  );

  srgb_pix_hold #(.PW(PW)) u_hold (
    .clk_i, .rst_ni, .ready_i(ready), .valid_i(pix_valid_i), .pix_i,
    .de_i(de), .slot_i(slot), .pix_o(held), .ok_o(ok), .underrun_o
  );

  srgb_byte_mux #(.CW(CW)) u_mux (
    .pix_i(held), .ok_i(ok), .de_i(de), .slot_i(slot), .order_i, .byte_o(data_o)
  );

  assign de_o        = de;
  assign pix_ready_o = ready;

  p_idle_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_o |-> (data_o == '0));
endmodule

// File: tb/srgb_serializer_tb.sv
module srgb_serializer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [9:0] hpw, hbp, hact, hfp, vpw, vbp, vact, vfp;
  logic [2:0] order;
  logic [23:0] pix;
  logic valid;
  logic ready, hs, vs, de, under;
  logic [7:0] data;

  srgb_serializer u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_hpw_i(hpw), .cfg_hbp_i(hbp), .cfg_hact_i(hact), .cfg_hfp_i(hfp),
    .cfg_vpw_i(vpw), .cfg_vbp_i(vbp), .cfg_vact_i(vact), .cfg_vfp_i(vfp),
    .order_i(order), .pix_i(pix), .pix_valid_i(valid), .pix_ready_o(ready),
    .data_o(data), .hsync_o(hs), .vsync_o(vs), .de_o(de), .underrun_o(under)
  );

  int total = 0, bad = 0;
  int t = 0;
  int miss_idx = -1;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s t=%0d actual=%0h expected=%0h", req, t, act, exp);
    end
  endtask

  function automatic logic [23:0] pval(input int h, input int v, input int f);
    return {4'h1, 4'(h + v), 4'h5, 4'(h * 3 + v + f), 4'hA, 4'(v * 5 + h + f)};
  endfunction

  function automatic int active(input int h, input int v);
    int hb = int'(hpw) + int'(hbp);
    int vb = int'(vpw) + int'(vbp);
    return int'(h >= hb && h < hb + int'(hact) && v >= vb && v < vb + int'(vact));
  endfunction

  function automatic logic [7:0] exp_byte(input logic [23:0] p, input int ord, input int slot);
    int ch;
    case (ord)
      1: ch = (slot == 0) ? 0 : (slot == 1) ? 2 : 1;
      2: ch = (slot == 0) ? 1 : (slot == 1) ? 0 : 2;
      3: ch = (slot == 0) ? 1 : (slot == 1) ? 2 : 0;
      4: ch = (slot == 0) ? 2 : (slot == 1) ? 0 : 1;
      5: ch = (slot == 0) ? 2 : (slot == 1) ? 1 : 0;
      default: ch = slot;
    endcase
    return (ch == 0) ? p[23:16] : (ch == 1) ? p[15:8] : p[7:0];
  endfunction

  // one clock: check state t at negedge, then drive inputs for the coming edge
  task automatic step();
    int htot = int'(hpw + hbp + hact + hfp);
    int vtot = int'(vpw + vbp + vact + vfp);
    int ph = t % 3, idx = t / 3;
    int h = idx % htot, v = (idx / htot) % vtot, f = idx / (htot * vtot);
    int ni = idx + 1;
    int nh = ni % htot, nv = (ni / htot) % vtot, nf = ni / (htot * vtot);
    int e_de = active(h, v);
    int e_d = 0;
    if (e_de != 0 && idx != miss_idx) e_d = int'(exp_byte(pval(h, v, f), int'(order), ph));
    chk("R3 hsync", int'(hs), int'(h < int'(hpw)));
    chk("R3 vsync", int'(vs), int'(v < int'(vpw)));
    chk("R4 de", int'(de), e_de);
    chk("R5 ready", int'(ready), int'(ph == 2 && active(nh, nv) != 0));
    if (idx == miss_idx) chk("R8 zero bytes", int'(data), 0);
    else if (e_de == 0) chk("R7 idle data", int'(data), 0);
    else chk("R6 R9 data", int'(data), e_d);
    chk("R8 underrun", int'(under), int'(miss_idx >= 0 && t > miss_idx * 3));
    pix   = pval(nh, nv, nf);
    valid = !(ni == miss_idx);
    t++;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    t = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset hsync", int'(hs), int'(hpw != 0));
    chk("R1 reset vsync", int'(vs), int'(vpw != 0));
    chk("R1 reset de", int'(de), 0);
    chk("R1 reset ready", int'(ready), 0);
    chk("R1 reset data", int'(data), 0);
    chk("R1 reset underrun", int'(under), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    int lim = 100000;
    repeat (lim) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R2 watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int fr;
    // R2 R3 R4 R5 R6 R8: 9 x 6 frame, 162 clocks
    hpw = 10'd2; hbp = 10'd1; hact = 10'd4; hfp = 10'd2;
    vpw = 10'd1; vbp = 10'd1; vact = 10'd3; vfp = 10'd1;
    order = 3'd0; valid = 1'b1; pix = '0;
    @(negedge clk);
    do_reset();
    miss_idx = 3 * 9 + 4; // R8: line 3, position 4
    pix = pval(1, 0, 0);
    fr = 9 * 6 * 3;
    for (int ord = 0; ord < 8; ord++) begin
      order = 3'(ord);
      for (int k = 0; k < fr; k++) step();
    end
    // R10: zero porches, 4 x 4 frame; reset clears underrun (R1)
    hpw = 10'd1; hbp = 10'd0; hact = 10'd3; hfp = 10'd0;
    vpw = 10'd1; vbp = 10'd0; vact = 10'd2; vfp = 10'd1;
    miss_idx = -1;
    order = 3'd5;
    do_reset();
    pix = pval(1, 0, 0);
    for (int k = 0; k < 3 * 4 * 4 * 3; k++) step();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule